// File: doc/BRIEF.md
# Condition Flag and Predicate Unit

This unit sits beside the integer ALU of a small pipelined core. When an instruction asks for its flags to be updated, the unit turns the ALU outcome into four status bits: negative, zero, carry and overflow. It latches them on the next clock edge. Compare instructions also use this path. They update the flags and write no register result, so the flags are their only visible effect.

Every instruction word carries a 4-bit condition in its top bits. The unit checks that condition against the stored flags and raises a pass signal. The issue logic uses this signal to decide whether the instruction, or a branch, takes effect. The same four flags support two families of ordering tests: a signed family and an unsigned family.

There is no sequential control here beyond the flag register. The condition field is decoded as a named enumeration in a single `unique case`. Its states are: EQ, NE, HS, LO, MI, PL, VS, VC, HI, LS, GE, LT, GT, LE, AL and NV. The only transition is the flag-register update, which happens when `set_flags` is 1 at a rising clock edge.

Top module: `cpf_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first update, all four flags read 0.
- R2: When `set_flags` is 1 at a rising edge, N takes bit 31 of `alu_result`, and Z becomes 1 exactly when `alu_result` is all zeros.
- R3: When `set_flags` is 1 at a rising edge, C takes `alu_carry`. For subtraction, the ALU supplies a carry of 1 when no borrow occurs.
- R4: With `op_is_sub` = 0 (add), an update sets V to 1 exactly when the two operand signs are equal and the result sign differs from them.
- R5: With `op_is_sub` = 1 (subtract), an update sets V to 1 exactly when the operand signs differ and the result sign differs from the first operand's sign.
- R6: When `set_flags` is 0 at an edge, all four flags keep their values, whatever the other inputs are.
- R7: `cond_pass` is combinational from the stored flags and `cond_code`. Code 0 (EQ) passes when Z=1, and code 1 (NE) passes when Z=0.
- R8: The single-flag codes are: 2 (HS) passes on C=1, 3 (LO) on C=0, 4 (MI) on N=1, 5 (PL) on N=0, 6 (VS) on V=1 and 7 (VC) on V=0.
- R9: The unsigned codes are: 8 (HI) passes on C=1 and Z=0, and 9 (LS) passes otherwise. Together with codes 2 and 3, they order the operands of a prior subtract as unsigned numbers.
- R10: The signed codes are: 10 (GE) passes when N equals V, 11 (LT) when N differs from V, 12 (GT) when Z=0 and N equals V, and 13 (LE) otherwise.
- R11: Code 14 (AL) always passes and code 15 (NV) never passes.
- R12: After subtracting 1 from 0xFFFFFFFF with flags set, code 3 (LO) fails and code 11 (LT) passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alu_result | input | 32 | ALU result of the current operation |
| alu_carry | input | 1 | Adder carry-out (no-borrow for subtract) |
| src_a_sign | input | 1 | Sign bit of the first operand |
| src_b_sign | input | 1 | Sign bit of the second operand |
| op_is_sub | input | 1 | Operation class: 0 add, 1 subtract |
| set_flags | input | 1 | Latch new flags at this edge |
| cond_code | input | 4 | Condition field of the current instruction |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| flag_v | output | 1 | Stored overflow flag |
| cond_pass | output | 1 | Condition holds for the stored flags |

## Verification
The assertions take for granted that `set_flags`, the operand sign bits and the result have known values at every sampled edge after reset. They do not assume that the sign inputs agree with the result. The bench changes inputs only at falling edges, so each update is seen at a single rising edge.

The sweep covers every reachable flag combination. Zero and negative never occur together, so that combination is left out. It also covers every operand-sign pattern, under both operation classes, and checks real subtract pairs against signed and unsigned orderings computed in the bench.

// File: rtl/cpf_pkg.sv
`timescale 1ns/1ps
package cpf_pkg;
    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_HS = 4'd2,  CC_LO = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cc_e;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_cls_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;
endpackage

// File: rtl/cpf_flag_gen.sv
`timescale 1ns/1ps
module cpf_flag_gen
    import cpf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] result,
    input  logic              carry_in,
    input  logic              a_sign,
    input  logic              b_sign,
    input  op_cls_e           op_cls,
    output flags_t            nxt
);
    localparam int MSB = DATA_W - 1;

    logic r_sign;
    logic ovf;

    assign r_sign = result[MSB];

    always_comb begin
        unique case (op_cls)
            OP_ADD: ovf = (a_sign == b_sign) && (r_sign != a_sign);
            OP_SUB: ovf = (a_sign != b_sign) && (r_sign != a_sign);
            default: ovf = 1'b0;
        endcase
    end

    always_comb begin
        nxt.n = r_sign;
        nxt.z = (result == '0);
        nxt.c = carry_in;
        nxt.v = ovf;
    end
endmodule

// File: rtl/cpf_flag_reg.sv
`timescale 1ns/1ps
module cpf_flag_reg
    import cpf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   upd,
    input  flags_t nxt,
    output flags_t cur
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (upd) begin
            cur <= nxt;
        end
    end

    assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(cur));
    assert_flag_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (cur.n == $past(nxt.n)) && (cur.z == $past(nxt.z)));
endmodule

// File: rtl/cpf_cond_eval.sv
`timescale 1ns/1ps
module cpf_cond_eval
    import cpf_pkg::*;
(
    input  flags_t     fl,
    input  logic [3:0] code,
    output logic       pass
);
    cc_e  cc;
    logic sgn_ge;
    logic uns_hi;

    assign cc     = cc_e'(code);
    assign sgn_ge = (fl.n == fl.v);
    assign uns_hi = fl.c && !fl.z;

    always_comb begin
        unique case (cc)
            CC_EQ: pass = fl.z;
            CC_NE: pass = !fl.z;
            CC_HS: pass = fl.c;
            CC_LO: pass = !fl.c;
            CC_MI: pass = fl.n;
            CC_PL: pass = !fl.n;
            CC_VS: pass = fl.v;
            CC_VC: pass = !fl.v;
            CC_HI: pass = uns_hi;
            CC_LS: pass = !uns_hi;
            CC_GE: pass = sgn_ge;
            CC_LT: pass = !sgn_ge;
            CC_GT: pass = !fl.z && sgn_ge;
            CC_LE: pass = fl.z || !sgn_ge;
            CC_AL: pass = 1'b1;
            CC_NV: pass = 1'b0;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/cpf_unit.sv
`timescale 1ns/1ps
module cpf_unit
    import cpf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_carry,
    input  logic              src_a_sign,
    input  logic              src_b_sign,
    input  logic              op_is_sub,
    input  logic              set_flags,
    input  logic [3:0]        cond_code,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v,
    output logic              cond_pass
);
    flags_t nxt_flags;
    flags_t cur_flags;

    cpf_flag_gen #(.DATA_W(DATA_W)) gen_i (
        .result   (alu_result),
        .carry_in (alu_carry),
        .a_sign   (src_a_sign),
        .b_sign   (src_b_sign),
        .op_cls   (op_cls_e'(op_is_sub)),
        .nxt      (nxt_flags)
    );

    cpf_flag_reg reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (set_flags),
        .nxt   (nxt_flags),
        .cur   (cur_flags)
    );

    cpf_cond_eval eval_i (
        .fl   (cur_flags),
        .code (cond_code),
        .pass (cond_pass)
    );

    assign flag_n = cur_flags.n;
    assign flag_z = cur_flags.z;
    assign flag_c = cur_flags.c;
    assign flag_v = cur_flags.v;

    assert_carry_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags |=> flag_c == $past(alu_carry));
    assert_always_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'd14) |-> cond_pass);
    assert_never_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'd15) |-> !cond_pass);
    assert_zero_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z |-> !flag_n);
endmodule

// File: tb/cpf_unit_tb_top.sv
`timescale 1ns/1ps
module cpf_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] alu_result = '0;
    logic        alu_carry = 1'b0;
    logic        src_a_sign = 1'b0;
    logic        src_b_sign = 1'b0;
    logic        op_is_sub = 1'b0;
    logic        set_flags = 1'b0;
    logic [3:0]  cond_code = 4'd0;
    logic        flag_n, flag_z, flag_c, flag_v, cond_pass;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cpf_unit dut_i (
        .clk(clk), .rst_n(rst_n), .alu_result(alu_result), .alu_carry(alu_carry),
        .src_a_sign(src_a_sign), .src_b_sign(src_b_sign), .op_is_sub(op_is_sub),
        .set_flags(set_flags), .cond_code(cond_code), .flag_n(flag_n),
        .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v), .cond_pass(cond_pass)
    );

    task automatic check(input logic got, input logic exp, input string req);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    function automatic logic ref_pass(input logic n, z, c, v, input int cc);
        case (cc)
            0: return z;
            1: return !z;
            2: return c;
            3: return !c;
            4: return n;
            5: return !n;
            6: return v;
            7: return !v;
            8: return c & !z;
            9: return !c | z;
            10: return n == v;
            11: return n != v;
            12: return !z & (n == v);
            13: return z | (n != v);
            14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input int cc);
        if (cc < 2) return "R7";
        if (cc < 8) return "R8";
        if (cc < 10) return "R9";
        if (cc < 14) return "R10";
        return "R11";
    endfunction

    // drive one update: inputs at a falling edge, latched at the next rising edge
    task automatic update(input logic [31:0] r, input logic cy, input logic sa,
                          input logic sb, input logic sub);
        @(negedge clk);
        alu_result = r; alu_carry = cy; src_a_sign = sa; src_b_sign = sb;
        op_is_sub = sub; set_flags = 1'b1;
        @(negedge clk);
        set_flags = 1'b0;
    endtask

    task automatic sweep_codes(input logic n, z, c, v);
        for (int cc = 0; cc < 16; cc++) begin
            cond_code = 4'(cc);
            #0.5;
            check(cond_pass, ref_pass(n, z, c, v, cc), req_of(cc));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: flags are zero during reset
        check(flag_n | flag_z | flag_c | flag_v, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(flag_n | flag_z | flag_c | flag_v, 1'b0, "R1");
        cond_code = 4'd0; #0.5;
        check(cond_pass, 1'b0, "R1");

        // every reachable flag combination, every condition code
        for (int nz = 0; nz < 3; nz++) begin
            for (int cv = 0; cv < 4; cv++) begin
                logic en, ez, ec, ev;
                logic [31:0] r;
                en = (nz == 2); ez = (nz == 1);
                ec = cv[1]; ev = cv[0];
                r = ez ? 32'h0 : (en ? 32'h8000_0000 : 32'h1);
                if (ev) update(r, ec, !en, !en, 1'b0);
                else    update(r, ec, 1'b0, 1'b1, 1'b0);
                check(flag_n, en, "R2");
                check(flag_z, ez, "R2");
                check(flag_c, ec, "R3");
                check(flag_v, ev, "R4");
                sweep_codes(en, ez, ec, ev);
            end
        end

        // overflow rule for both classes over all sign patterns
        for (int sub = 0; sub < 2; sub++) begin
            for (int p = 0; p < 8; p++) begin
                logic sa, sb, rs, ev;
                sa = p[2]; sb = p[1]; rs = p[0];
                ev = sub ? ((sa != sb) && (rs != sa)) : ((sa == sb) && (rs != sa));
                update({rs, 31'h5}, 1'b0, sa, sb, sub[0]);
                check(flag_v, ev, sub ? "R5" : "R4");
            end
        end

        // R6: no update when set_flags is 0
        update(32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        alu_result = 32'h8000_0000; alu_carry = 1'b0; src_a_sign = 1'b0;
        src_b_sign = 1'b0; op_is_sub = 1'b0; set_flags = 1'b0;
        @(negedge clk);
        check(flag_z, 1'b1, "R6");
        check(flag_c, 1'b1, "R6");
        check(flag_n, 1'b0, "R6");
        check(flag_v, 1'b0, "R6");

        // real subtract pairs: signed and unsigned orderings (R9, R10, R12)
        for (int k = 0; k < 8; k++) begin
            logic [31:0] a, b, d;
            logic [32:0] w;
            case (k)
                0: begin a = 32'hFFFF_FFFF; b = 32'h1; end
                1: begin a = 32'h1; b = 32'hFFFF_FFFF; end
                2: begin a = 32'h5; b = 32'h5; end
                3: begin a = 32'h8000_0000; b = 32'h1; end
                4: begin a = 32'h7FFF_FFFF; b = 32'h8000_0000; end
                5: begin a = 32'h0; b = 32'h0; end
                6: begin a = 32'h3; b = 32'h7; end
                default: begin a = 32'h8000_0000; b = 32'h8000_0000; end
            endcase
            w = {1'b0, a} - {1'b0, b};
            d = w[31:0];
            update(d, !w[32], a[31], b[31], 1'b1);
            cond_code = 4'd0;  #0.5; check(cond_pass, a == b, "R7");
            cond_code = 4'd2;  #0.5; check(cond_pass, a >= b, "R9");
            cond_code = 4'd3;  #0.5; check(cond_pass, a < b, k == 0 ? "R12" : "R9");
            cond_code = 4'd8;  #0.5; check(cond_pass, a > b, "R9");
            cond_code = 4'd9;  #0.5; check(cond_pass, a <= b, "R9");
            cond_code = 4'd10; #0.5; check(cond_pass, $signed(a) >= $signed(b), "R10");
            cond_code = 4'd11; #0.5; check(cond_pass, $signed(a) < $signed(b), k == 0 ? "R12" : "R10");
            cond_code = 4'd12; #0.5; check(cond_pass, $signed(a) > $signed(b), "R10");
            cond_code = 4'd13; #0.5; check(cond_pass, $signed(a) <= $signed(b), "R10");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule